// File: doc/BRIEF.md
# Orthogonal Gold Spreading Code Pool

This block builds a set of N spreading codes of N chips each for a code-division crossbar and hands them out to ports on request. After reset it runs two maximal-length linear feedback shift registers of degree log2(N), fed by a pair of primitive polynomials, for N-1 steps. It captures both m-sequences and then writes N codes into a small code memory. Code 0 is the first m-sequence alone. Code k (k >= 1) is the first m-sequence XORed with the second m-sequence cyclically shifted by k-1. Every code gets a leading zero chip, so each length N-1 Gold sequence becomes an N-chip code. The whole set of N codes is used.

Once the memory is full a ready flag rises. Each port then raises a one-cycle request and receives one code, chosen as the lowest-numbered free code. The grant reports the port, the code index and the N chips. The port keeps the code until it pulses its release line. Requests that find no free code wait inside the pool until a code comes back. When several ports wait, they are served one per cycle in order of port number.

Top module: `orth_gold_pool`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ready` and `gnt_valid` are 0.
- R2: `ready` rises exactly 2N-1 rising clock edges after the first edge with reset low, and stays high until the next reset.
- R3: Chip i of a code is bit i of `gnt_code`, and chip 0 is always 0. Let a_j and b_j be two sequences with a_0..a_{m-1} = b_0..b_{m-1} = 1 (m = log2 N). For N=8 they follow a_{j+3} = a_{j+1} ^ a_j and b_{j+3} = b_{j+2} ^ b_j. For i = 1..N-1, chip i of code 0 is a_{i-1}, and chip i of code k (k >= 1) is a_{i-1} ^ b_{(i+k-2) mod (N-1)}.
- R4: Code 0 holds exactly N/2 ones. All N codes are pairwise distinct.
- R5: No grant is issued before `ready` is high. A request made earlier stays pending and is granted in the cycle after `ready` is first seen high.
- R6: A request pulse sampled at one clock edge produces a grant at the next edge, provided a code is free and no lower-numbered port is waiting. The grant carries the lowest-numbered waiting port, the lowest-numbered free code index, and that code's chips.
- R7: At most one grant is issued per cycle. `gnt_valid` is a single-cycle pulse per grant.
- R8: When every code is taken, waiting requests are held without a grant. A release pulse from a port that holds a code frees that code. The code is granted to the lowest waiting port at the edge after the release is sampled.
- R9: A request from a port that already holds a code is ignored. A release from a port that holds no code is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NPORT | Per-port one-cycle code request |
| rel | input | NPORT | Per-port one-cycle release of the held code |
| ready | output | 1 | All N codes are generated and stored |
| gnt_valid | output | 1 | One-cycle grant strobe |
| gnt_port | output | $clog2(NPORT) | Port receiving the grant |
| gnt_idx | output | log2(N) | Index of the granted code |
| gnt_code | output | N | Granted code, chip i on bit i |

## Verification
The bench builds the block with N=8 and NPORT=10. Because there are more ports than codes, a single burst of requests drains the pool completely and leaves two ports waiting. This exposes every one of the eight generated codes through the grant port, so each can be compared with sequences computed in the bench. It also makes the full-pool, pending-request and release-refill paths reachable in a few dozen cycles. With degree-3 registers, the 15-cycle start-up can be counted edge by edge, so the ready timing and the pre-ready request are checked exactly.

// File: rtl/gold_pkg.sv
package gold_pkg;
  // Primitive polynomial masks for the Fibonacci recurrence
  // s[j+m] = XOR of s[j+i] for every set bit i of the mask.
  function automatic int gold_tap(input int m, input int which);
    case (m)
      2:       return 3;
      3:       return (which == 0) ? 3 : 5;
      4:       return (which == 0) ? 3 : 9;
      5:       return (which == 0) ? 5 : 29;
      6:       return (which == 0) ? 3 : 33;
      default: return 3;
    endcase
  endfunction

  typedef enum logic [1:0] {
    GEN_SHIFT = 2'd0,
    GEN_FILL  = 2'd1,
    GEN_DONE  = 2'd2
  } gen_state_t;
endpackage

// File: rtl/gold_lfsr.sv
module gold_lfsr #(
  parameter int M = 3,
  parameter logic [M-1:0] TAP = 3'b011
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic bit_o
);
  logic [M-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= '1;
    else if (step) st <= {^(st & TAP), st[M-1:1]};
  end

  assign bit_o = st[0];

  p_never_zero_r3: assert property (@(posedge clk) disable iff (rst) st != '0);
endmodule

// File: rtl/gold_seq_builder.sv
module gold_seq_builder
  import gold_pkg::*;
#(
  parameter int N = 8,
  localparam int M = $clog2(N),
  localparam int L = N - 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic         wr_en,
  output logic [M-1:0] wr_addr,
  output logic [N-1:0] wr_data,
  output logic         ready
);
  localparam logic [M-1:0] TAP_A = M'(gold_tap(M, 0));
  localparam logic [M-1:0] TAP_B = M'(gold_tap(M, 1));

  gen_state_t   state;
  logic [M-1:0] cnt;
  logic [L-1:0] seq_a, seq_b, rot_b;
  logic         bit_a, bit_b, step;

  assign step = (state == GEN_SHIFT);

  gold_lfsr #(.M(M), .TAP(TAP_A)) u_lfsr_a (.clk(clk), .rst(rst), .step(step), .bit_o(bit_a));
  gold_lfsr #(.M(M), .TAP(TAP_B)) u_lfsr_b (.clk(clk), .rst(rst), .step(step), .bit_o(bit_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= GEN_SHIFT;
      cnt   <= '0;
      seq_a <= '0;
      seq_b <= '0;
      rot_b <= '0;
      ready <= 1'b0;
    end else begin
      case (state)
        GEN_SHIFT: begin
          seq_a <= {bit_a, seq_a[L-1:1]};
          seq_b <= {bit_b, seq_b[L-1:1]};
          if (cnt == M'(L - 1)) begin
            state <= GEN_FILL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        GEN_FILL: begin
          if (cnt == '0) rot_b <= seq_b;
          else           rot_b <= {rot_b[0], rot_b[L-1:1]};
          if (cnt == M'(N - 1)) begin
            state <= GEN_DONE;
            ready <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= GEN_DONE;
      endcase
    end
  end

  always_comb begin
    wr_en   = (state == GEN_FILL);
    wr_addr = cnt;
    if (cnt == '0) wr_data = {seq_a, 1'b0};
    else           wr_data = {seq_a ^ rot_b, 1'b0};
  end

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst) !$fell(ready));
  p_fill_before_ready_r2: assert property (@(posedge clk) disable iff (rst) wr_en |-> !ready);
  p_chip0_zero_r3: assert property (@(posedge clk) disable iff (rst) wr_en |-> !wr_data[0]);
endmodule

// File: rtl/gold_code_ram.sv
module gold_code_ram #(
  parameter int N = 8,
  localparam int M = $clog2(N)
) (
  input  logic         clk,
  input  logic         we,
  input  logic [M-1:0] wa,
  input  logic [N-1:0] wd,
  input  logic [M-1:0] ra,
  output logic [N-1:0] rd
);
  logic [N-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd <= mem[ra];
  end
endmodule

// File: rtl/gold_pool_alloc.sv
module gold_pool_alloc #(
  parameter int N = 8,
  parameter int NPORT = 10,
  localparam int M = $clog2(N),
  localparam int PW = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] rel,
  output logic [M-1:0]     rd_addr,
  output logic             gnt_valid,
  output logic [PW-1:0]    gnt_port,
  output logic [M-1:0]     gnt_idx
);
  logic [N-1:0]     busy, busy_n;
  logic [NPORT-1:0] pend, pend_n, hold, hold_n;
  logic [M-1:0]     owner [NPORT];
  logic [PW-1:0]    p_sel;
  logic [M-1:0]     f_sel;
  logic             fire;

  always_comb begin
    p_sel = '0;
    for (int i = NPORT - 1; i >= 0; i--) if (pend[i]) p_sel = PW'(i);
    f_sel = '0;
    for (int i = N - 1; i >= 0; i--) if (!busy[i]) f_sel = M'(i);
    fire    = ready && (|pend) && !(&busy);
    rd_addr = f_sel;

    busy_n = busy;
    hold_n = hold;
    pend_n = pend | (req & ~hold);
    for (int p = 0; p < NPORT; p++) begin
      if (rel[p] && hold[p]) begin
        busy_n[owner[p]] = 1'b0;
        hold_n[p]        = 1'b0;
      end
    end
    if (fire) begin
      busy_n[f_sel] = 1'b1;
      hold_n[p_sel] = 1'b1;
      pend_n[p_sel] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= '0;
      pend      <= '0;
      hold      <= '0;
      gnt_valid <= 1'b0;
      gnt_port  <= '0;
      gnt_idx   <= '0;
    end else begin
      busy      <= busy_n;
      pend      <= pend_n;
      hold      <= hold_n;
      gnt_valid <= fire;
      if (fire) begin
        gnt_port <= p_sel;
        gnt_idx  <= f_sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) owner[p_sel] <= f_sel;
  end

  p_no_grant_early_r5: assert property (@(posedge clk) disable iff (rst) !ready |=> !gnt_valid);
  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst) (&busy) |=> !gnt_valid);
  p_granted_busy_r6: assert property (@(posedge clk) disable iff (rst) gnt_valid |-> busy[gnt_idx]);
  p_holder_not_pending_r9: assert property (@(posedge clk) disable iff (rst) (pend & hold) == '0);
endmodule

// File: rtl/orth_gold_pool.sv
module orth_gold_pool #(
  parameter int N = 8,
  parameter int NPORT = 10,
  localparam int M = $clog2(N),
  localparam int PW = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] rel,
  output logic             ready,
  output logic             gnt_valid,
  output logic [PW-1:0]    gnt_port,
  output logic [M-1:0]     gnt_idx,
  output logic [N-1:0]     gnt_code
);
  logic         wr_en;
  logic [M-1:0] wr_addr, rd_addr;
  logic [N-1:0] wr_data;

  gold_seq_builder #(.N(N)) u_build (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ready(ready)
  );

  gold_code_ram #(.N(N)) u_ram (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr), .rd(gnt_code)
  );

  gold_pool_alloc #(.N(N), .NPORT(NPORT)) u_pool (
    .clk(clk), .rst(rst), .ready(ready), .req(req), .rel(rel),
    .rd_addr(rd_addr), .gnt_valid(gnt_valid), .gnt_port(gnt_port),
    .gnt_idx(gnt_idx)
  );

  p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> (!gnt_valid || !$stable(gnt_idx)));
endmodule

// File: tb/sim_orth_gold_pool.sv
module sim_orth_gold_pool;
  localparam int N = 8;
  localparam int NPORT = 10;
  localparam int M = $clog2(N);
  localparam int PW = $clog2(NPORT);
  localparam int L = N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPORT-1:0] req = '0, rel = '0;
  logic ready, gnt_valid;
  logic [PW-1:0] gnt_port;
  logic [M-1:0] gnt_idx;
  logic [N-1:0] gnt_code;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] expc [N];
  logic [N-1:0] seen [N];

  always #2.5 clk = ~clk;

  orth_gold_pool #(.N(N), .NPORT(NPORT)) u0 (
    .clk(clk), .rst(rst), .req(req), .rel(rel), .ready(ready),
    .gnt_valid(gnt_valid), .gnt_port(gnt_port), .gnt_idx(gnt_idx),
    .gnt_code(gnt_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [NPORT-1:0] v);
    req = v; cyc(); req = '0;
  endtask

  task automatic pulse_rel(input logic [NPORT-1:0] v);
    rel = v; cyc(); rel = '0;
  endtask

  task automatic expect_grant(input int port, input int idx, input string tag);
    cyc();
    chk(gnt_valid === 1'b1, {tag, " valid"}, int'(gnt_valid), 1);
    chk(int'(gnt_port) == port, {tag, " port"}, int'(gnt_port), port);
    chk(int'(gnt_idx) == idx, {tag, " idx"}, int'(gnt_idx), idx);
    chk(gnt_code == expc[idx], {tag, " code R3"}, int'(gnt_code), int'(expc[idx]));
  endtask

  task automatic expect_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc();
      chk(gnt_valid === 1'b0, tag, int'(gnt_valid), 0);
    end
  endtask

  initial begin
    logic [L-1:0] a, b;
    for (int j = 0; j < L; j++) begin
      if (j < M) begin a[j] = 1'b1; b[j] = 1'b1; end
      else begin
        a[j] = a[j-2] ^ a[j-3];
        b[j] = b[j-1] ^ b[j-3];
      end
    end
    for (int k = 0; k < N; k++) begin
      expc[k][0] = 1'b0;
      for (int i = 1; i < N; i++)
        expc[k][i] = (k == 0) ? a[i-1] : (a[i-1] ^ b[(i + k - 2) % L]);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ones;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready === 1'b0, "R1 ready in reset", int'(ready), 0);
    chk(gnt_valid === 1'b0, "R1 grant in reset", int'(gnt_valid), 0);
    rst = 1'b0;
    for (int c = 1; c <= 2 * N - 1; c++) begin
      if (c == 3) req = 10'b0000000010;
      cyc();
      req = '0;
      if (c == 1) chk(ready === 1'b0, "R1 ready after reset", int'(ready), 0);
      if (c == 2 * N - 2) chk(ready === 1'b0, "R2 ready early", int'(ready), 0);
      if (c == 2 * N - 1) chk(ready === 1'b1, "R2 ready on time", int'(ready), 1);
      chk(gnt_valid === 1'b0, "R5 no grant before ready", int'(gnt_valid), 0);
    end
    expect_grant(1, 0, "R5 held request");
    expect_quiet(1, "R7 single pulse");
    pulse_rel(10'b0000000010);

    // burst from all ports drains the pool
    pulse_req('1);
    for (int k = 0; k < N; k++) begin
      expect_grant(k, k, "R6 R7 burst");
      seen[k] = gnt_code;
    end
    expect_quiet(3, "R8 full pool holds");
    ones = $countones(seen[0]);
    chk(ones == N / 2, "R4 code0 balance", ones, N / 2);
    for (int x = 0; x < N; x++)
      for (int y = x + 1; y < N; y++)
        chk(seen[x] != seen[y], "R4 distinct codes", int'(seen[x]), int'(seen[y]));

    pulse_rel(10'b0100000000);
    expect_quiet(3, "R9 release without code");
    pulse_rel(10'b0000001000);
    expect_grant(8, 3, "R8 refill after release");
    pulse_rel(10'b0000100000);
    expect_grant(9, 5, "R8 second refill");

    pulse_rel(10'b0010000000);
    expect_quiet(1, "R8 nobody waiting");
    pulse_req(10'b0000000001);
    expect_quiet(3, "R9 request while holding");
    pulse_req(10'b0010000000);
    expect_grant(7, 7, "R6 single free code");

    pulse_rel('1);
    pulse_req(10'b0000010100);
    expect_grant(2, 0, "R6 lowest port first");
    expect_grant(4, 1, "R6 R7 next port");
    expect_quiet(2, "R7 no extra grant");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule